// File: doc/BRIEF.md
# Reloadable Millisecond Interval Timer

This block raises a periodic interrupt whose period software sets. It counts ticks of an external 1 ms strobe. The period is the programmed reload value plus one, in milliseconds, so a reload of zero gives an interrupt every millisecond. The timer runs freely: each time a period ends, the next one starts at once, and software does not need to re-arm it.

Software controls the timer with two operations. Writing a new reload value drops any pending interrupt and starts a fresh period from that value. Reading the count register always returns zero and acknowledges the interrupt. The interrupt is a level output. It stays high until software acknowledges it or writes a new reload value.

Top module: `itmr_interval_timer`

## Requirements
- R1: After reset the reload value is 0 and `irq_o` is low, so the first strobe pulse sets `irq_o` in the cycle after it.
- R2: With reload value N, `irq_o` rises in the cycle after the (N+1)-th strobe pulse counted from the start of the period.
- R3: A reload write sets `irq_o` low in the next cycle and restarts the period from count zero, using the written value.
- R4: When a period ends, the next period starts with no software action. `irq_o` stays high until it is cleared, and the timer expires again after another N+1 strobe pulses.
- R5: In the cycle after a count read, `count_data_o` is all zeros.
- R6: A count read with no expiry and no reload write in the same cycle sets `irq_o` low in the next cycle.
- R7: If a count read and an expiry fall in the same cycle, the expiry wins and `irq_o` is high in the next cycle.
- R8: A reload write takes priority over a strobe pulse in the same cycle, including one that would end the period: `irq_o` is low next cycle and counting starts from zero.
- R9: Cycles without a strobe pulse do not advance the period, and `irq_o` holds its value through them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_ms_i | input | 1 | One-cycle strobe, once per millisecond |
| reload_wr_i | input | 1 | Write strobe for the reload register |
| reload_data_i | input | RELOAD_W | New reload value |
| count_rd_i | input | 1 | Read strobe for the count register (acknowledges the interrupt) |
| count_data_o | output | RELOAD_W | Registered read data, always zero |
| irq_o | output | 1 | Registered interrupt level |

## Verification
Assertions check the following on every cycle:
- the period counter never passes the reload value;
- the counter stays still when there is no strobe;
- a reload write clears the interrupt in the next cycle;
- a plain acknowledge clears the interrupt in the next cycle;
- the interrupt flag follows the set, clear and hold commands given to it.

Only the bench scenarios can show that the full period is exactly reload+1 strobe pulses, that the timer re-arms over several periods, and that the same-cycle collisions resolve in the right order (acknowledge against expiry, write against expiry). The bench shows these by comparing the interrupt, cycle by cycle, with a reference model under random traffic.

// File: rtl/itmr_pkg.sv
package itmr_pkg;
  parameter int unsigned ITMR_RELOAD_W = 16;

  typedef enum logic [1:0] {
    IRQ_HOLD  = 2'd0,
    IRQ_CLEAR = 2'd1,
    IRQ_SET   = 2'd2
  } irq_act_e;
endpackage

// File: rtl/itmr_period_cnt.sv
module itmr_period_cnt #(
  parameter int unsigned RELOAD_W = itmr_pkg::ITMR_RELOAD_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tick_i,
  input  logic                load_i,
  input  logic [RELOAD_W-1:0] load_val_i,
  output logic                expire_o
);
  logic [RELOAD_W-1:0] reload_q;
  logic [RELOAD_W-1:0] cnt_q;
  logic                at_end;

  assign at_end   = (cnt_q == reload_q);
  assign expire_o = tick_i && !load_i && at_end;

  always_ff @(posedge clk) begin
    if (rst) begin
      reload_q <= '0;
      cnt_q    <= '0;
    end else if (load_i) begin
      reload_q <= load_val_i;
      cnt_q    <= '0;
    end else if (tick_i) begin
      if (at_end) cnt_q <= '0;
      else        cnt_q <= cnt_q + 1'b1;
    end
  end

  // R2
  cnt_in_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= reload_q);

  // R3
  load_restart_chk: assert property (@(posedge clk) disable iff (rst)
    load_i |=> (cnt_q == '0));

  // R9
  idle_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick_i && !load_i) |=> $stable(cnt_q));
endmodule

// File: rtl/itmr_irq_flag.sv
module itmr_irq_flag
  import itmr_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  irq_act_e act_i,
  output logic     irq_o
);
  logic irq_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q <= 1'b0;
    end else begin
      case (act_i)
        IRQ_SET:   irq_q <= 1'b1;
        IRQ_CLEAR: irq_q <= 1'b0;
        default:   irq_q <= irq_q;
      endcase
    end
  end

  assign irq_o = irq_q;

  // R4
  set_raises_chk: assert property (@(posedge clk) disable iff (rst)
    (act_i == IRQ_SET) |=> irq_q);

  // R6
  clear_lowers_chk: assert property (@(posedge clk) disable iff (rst)
    (act_i == IRQ_CLEAR) |=> !irq_q);

  // R9
  hold_keeps_chk: assert property (@(posedge clk) disable iff (rst)
    (act_i == IRQ_HOLD) |=> $stable(irq_q));
endmodule

// File: rtl/itmr_interval_timer.sv
module itmr_interval_timer
  import itmr_pkg::*;
#(
  parameter int unsigned RELOAD_W = ITMR_RELOAD_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tick_ms_i,
  input  logic                reload_wr_i,
  input  logic [RELOAD_W-1:0] reload_data_i,
  input  logic                count_rd_i,
  output logic [RELOAD_W-1:0] count_data_o,
  output logic                irq_o
);
  logic     expire;
  irq_act_e act;
  logic [RELOAD_W-1:0] rdata_q;

  itmr_period_cnt #(.RELOAD_W(RELOAD_W)) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .tick_i     (tick_ms_i),
    .load_i     (reload_wr_i),
    .load_val_i (reload_data_i),
    .expire_o   (expire)
  );

  // Priority: reload write, then expiry, then acknowledge.
  always_comb begin
    if (reload_wr_i)     act = IRQ_CLEAR;
    else if (expire)     act = IRQ_SET;
    else if (count_rd_i) act = IRQ_CLEAR;
    else                 act = IRQ_HOLD;
  end

  itmr_irq_flag u_irq (
    .clk   (clk),
    .rst   (rst),
    .act_i (act),
    .irq_o (irq_o)
  );

  // The count register has no live value; a read always returns zero.
  always_ff @(posedge clk) begin
    if (rst || count_rd_i) rdata_q <= '0;
  end
  assign count_data_o = rdata_q;

  // R3
  wr_clears_irq_chk: assert property (@(posedge clk) disable iff (rst)
    reload_wr_i |=> !irq_o);

  // R6
  ack_clears_irq_chk: assert property (@(posedge clk) disable iff (rst)
    (count_rd_i && !reload_wr_i && !tick_ms_i) |=> !irq_o);

  // R5
  read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    count_rd_i |=> (count_data_o == '0));
endmodule

// File: tb/itmr_interval_timer_bench.sv
module itmr_interval_timer_bench;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         tick = 1'b0;
  logic         wr = 1'b0;
  logic [W-1:0] wdata = '0;
  logic         rd = 1'b0;
  logic [W-1:0] rdata;
  logic         irq;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  // Reference model state
  int m_reload = 0;
  int m_cnt    = 0;
  bit m_irq    = 1'b0;

  always #4 clk = ~clk;

  itmr_interval_timer #(.RELOAD_W(W)) u_itmr_interval_timer (
    .clk           (clk),
    .rst           (rst),
    .tick_ms_i     (tick),
    .reload_wr_i   (wr),
    .reload_data_i (wdata),
    .count_rd_i    (rd),
    .count_data_o  (rdata),
    .irq_o         (irq)
  );

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic void model_step(input bit w, input int d, input bit r, input bit t);
    if (w) begin
      m_reload = d; m_cnt = 0; m_irq = 1'b0;
    end else if (t && m_cnt == m_reload) begin
      m_cnt = 0; m_irq = 1'b1;
    end else begin
      if (t) m_cnt++;
      if (r) m_irq = 1'b0;
    end
  endfunction

  // Drive at negedge, step one clock, return at the next negedge.
  task automatic step(input bit w, input int d, input bit r, input bit t);
    wr = w; wdata = W'(d); rd = r; tick = t;
    model_step(w, d, r, t);
    @(posedge clk);
    @(negedge clk);
    wr = 1'b0; rd = 1'b0; tick = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 1);
  endtask

  initial begin
    void'($urandom(32'h5eed1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 reset irq", irq, 0);

    // R1: reload 0 after reset, one strobe expires
    step(0, 0, 0, 1);
    check("R1 first tick irq", irq, 1);

    // R6, R5: acknowledge
    step(0, 0, 1, 0);
    check("R6 ack irq", irq, 0);
    check("R5 read data", rdata, 0);

    // R3, R2: reload 3 gives 4-tick period
    step(0, 0, 0, 1);
    check("R1 again irq", irq, 1);
    step(1, 3, 0, 0);
    check("R3 write clears irq", irq, 0);
    ticks(3);
    check("R2 before end irq", irq, 0);
    step(0, 0, 0, 1);
    check("R2 expiry irq", irq, 1);

    // R9: idle cycles hold state
    for (int i = 0; i < 5; i++) step(0, 0, 0, 0);
    check("R9 idle holds irq", irq, 1);
    step(0, 0, 1, 0);
    ticks(3);
    check("R9 idle did not advance", irq, 0);
    step(0, 0, 0, 1);
    check("R4 rearm expiry", irq, 1);

    // R4: stays high unacked over another period
    ticks(4);
    check("R4 stays high", irq, 1);
    step(0, 0, 1, 0);
    ticks(4);
    check("R4 second rearm", irq, 1);

    // R7: ack coincides with expiry
    step(1, 1, 0, 0);
    step(0, 0, 0, 1);
    check("R7 mid period", irq, 0);
    step(0, 0, 1, 1);
    check("R7 expiry beats ack", irq, 1);

    // R8: write coincides with expiring tick
    step(1, 0, 0, 0);
    step(1, 2, 0, 1);
    check("R8 write beats expiry", irq, 0);
    ticks(2);
    check("R8 count restarted", irq, 0);
    step(0, 0, 0, 1);
    check("R8 new period end", irq, 1);

    // R3: write clears a pending irq and restarts mid-period
    step(1, 5, 0, 0);
    ticks(3);
    step(1, 1, 0, 1);
    ticks(1);
    check("R3 restart mid period", irq, 0);
    ticks(1);
    check("R3 restarted period end", irq, 1);

    // Random traffic against the model (R2, R4, R6, R7, R8)
    for (int i = 0; i < 4000; i++) begin
      bit w, r, t;
      w = ($urandom_range(0, 39) == 0);
      r = ($urandom_range(0, 9) == 0);
      t = ($urandom_range(0, 2) != 0);
      step(w, int'($urandom_range(0, 6)), r, t);
      check("R2 random irq", irq, m_irq);
      if (r) check("R5 random read", rdata, 0);
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule